// File: doc/BRIEF.md
# Bidirectional Four-Lane Cascadable Column Shift Register

This block collects column data for a display column driver. A 4-bit nibble is taken in on every rising edge of the shift clock. Each bit of the nibble feeds its own 16-stage lane, so 16 clocks fill all 64 stages. The 64 stage values are always visible as one parallel word, which a downstream latch captures.

The block has two nibble ports, A and B. A direction select decides which of them is the input and which is the cascade output. When the select is low (forward), nibbles enter on A and the oldest nibble leaves on B. When the select is high (reverse), nibbles enter on B, the shift order inside every lane is mirrored, and the oldest nibble leaves on A. Devices can therefore be chained in either direction to cover any column count. Each port is split into an input, an output and an output enable, so a pad ring can form the tri-state pin.

Top module: `col_shift_reg`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears all 64 stages at once, and both data outputs then read zero.
- R2: Forward (`rev_i`=0): on each rising clock edge, `par_o[n+4]` takes the old `par_o[n]` for n = 0..59, and `par_o[3:0]` takes `a_i`, with `a_i[k]` going to `par_o[k]`.
- R3: Reverse (`rev_i`=1): on each rising clock edge, `par_o[n]` takes the old `par_o[n+4]` for n = 0..59, and `par_o[63:60]` takes `b_i`, with `b_i[k]` going to `par_o[60+k]`.
- R4: Lane k (k = 0..3, fed by data bit k) holds stage j (j = 0..15) at `par_o[4*j+k]`. Lane 0 therefore covers bits 0, 4, ..., 60, and lane 3 covers bits 3, 7, ..., 63.
- R5: In forward mode `b_o` equals `par_o[63:60]`. A nibble presented on `a_i` before a given edge appears on `b_o` right after the 16th edge counted from that one, and not before.
- R6: In reverse mode `a_o` equals `par_o[3:0]`. A nibble presented on `b_i` before a given edge appears on `a_o` right after the 16th edge counted from that one, and not before.
- R7: Only the output port drives. Forward gives `b_oe_o`=1 and `a_oe_o`=0. Reverse gives `a_oe_o`=1 and `b_oe_o`=0. The data output of the port that is not enabled reads zero. The enables follow `rev_i` without waiting for a clock.
- R8: The input of the port acting as output has no effect on the register: `b_i` in forward mode, `a_i` in reverse mode.
- R9: Changing `rev_i` keeps the stored contents. The next edges shift the other way, so nibbles loaded forward come back out on `a_o`, newest first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_i | input | 1 | Direction select: 0 forward, 1 reverse |
| a_i | input | 4 | A port input nibble (data in when forward) |
| b_i | input | 4 | B port input nibble (data in when reverse) |
| a_o | output | 4 | A port output nibble (cascade out when reverse) |
| a_oe_o | output | 1 | A port output enable |
| b_o | output | 4 | B port output nibble (cascade out when forward) |
| b_oe_o | output | 1 | B port output enable |
| par_o | output | 64 | Parallel stage word for the downstream latch |

## Verification
The hardest case to reach from the ports is a turnaround in the middle of a load. Contents written in one direction must be read back in the other, and only the stored stages tie the two halves together. The stimulus gets there by reset, then a few distinct nibbles loaded forward, then a switch of `rev_i` between edges. The bench checks `a_o` at once and after each reverse edge. The 16-edge cascade latency is checked on the cycle before and the cycle of arrival in both directions. Junk is driven on the unused input port all the while.

// File: rtl/col_shift_pkg.sv
package col_shift_pkg;
  localparam int unsigned LANE_CNT  = 4;
  localparam int unsigned LANE_DEPTH = 16;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/col_shift_lane.sv
module col_shift_lane
  import col_shift_pkg::*;
#(
  parameter int unsigned DEPTH = LANE_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shift_dir_e       dir_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] q_o
);
  logic [DEPTH-1:0] q;

  // forward moves toward the top stage, reverse toward stage 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q <= '0;
    else if (dir_i == DIR_FWD) q <= {q[DEPTH-2:0], din_i};
    else                      q <= {din_i, q[DEPTH-1:1]};
  end

  assign q_o = q;
endmodule

// File: rtl/col_shift_port.sv
module col_shift_port
  import col_shift_pkg::*;
#(
  parameter int unsigned LANES = LANE_CNT
) (
  input  shift_dir_e       dir_i,
  input  logic [LANES-1:0] a_i,
  input  logic [LANES-1:0] b_i,
  input  logic [LANES-1:0] head_i,
  input  logic [LANES-1:0] tail_i,
  output logic [LANES-1:0] lane_din_o,
  output logic [LANES-1:0] a_o,
  output logic             a_oe_o,
  output logic [LANES-1:0] b_o,
  output logic             b_oe_o
);
  always_comb begin
    if (dir_i == DIR_FWD) begin
      lane_din_o = a_i;
      b_o        = tail_i;
      b_oe_o     = 1'b1;
      a_o        = '0;
      a_oe_o     = 1'b0;
    end else begin
      lane_din_o = b_i;
      a_o        = head_i;
      a_oe_o     = 1'b1;
      b_o        = '0;
      b_oe_o     = 1'b0;
    end
  end
endmodule

// File: rtl/col_shift_reg.sv
module col_shift_reg
  import col_shift_pkg::*;
#(
  parameter int unsigned LANES = LANE_CNT,
  parameter int unsigned DEPTH = LANE_DEPTH,
  localparam int unsigned W    = LANES * DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rev_i,
  input  logic [LANES-1:0] a_i,
  input  logic [LANES-1:0] b_i,
  output logic [LANES-1:0] a_o,
  output logic             a_oe_o,
  output logic [LANES-1:0] b_o,
  output logic             b_oe_o,
  output logic [W-1:0]     par_o
);
  shift_dir_e       dir;
  logic [LANES-1:0] lane_din;
  logic [LANES-1:0] head;
  logic [LANES-1:0] tail;
  logic [DEPTH-1:0] lane_q [LANES];

  assign dir = rev_i ? DIR_REV : DIR_FWD;

  col_shift_port #(.LANES(LANES)) u_port (
    .dir_i      (dir),
    .a_i        (a_i),
    .b_i        (b_i),
    .head_i     (head),
    .tail_i     (tail),
    .lane_din_o (lane_din),
    .a_o        (a_o),
    .a_oe_o     (a_oe_o),
    .b_o        (b_o),
    .b_oe_o     (b_oe_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    col_shift_lane #(.DEPTH(DEPTH)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dir_i  (dir),
      .din_i  (lane_din[l]),
      .q_o    (lane_q[l])
    );
    assign head[l] = lane_q[l][0];
    assign tail[l] = lane_q[l][DEPTH-1];
    // interleave: stage j of lane l lands on bit j*LANES+l
    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      assign par_o[j*LANES+l] = lane_q[l][j];
    end
  end
endmodule

// File: rtl/col_shift_reg_chk.sv
module col_shift_reg_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned W    = LANES * DEPTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rev_i,
  input logic [LANES-1:0] a_i,
  input logic [LANES-1:0] b_i,
  input logic [LANES-1:0] a_o,
  input logic             a_oe_o,
  input logic [LANES-1:0] b_o,
  input logic             b_oe_o,
  input logic [W-1:0]     par_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (par_o == '0); // R1
  end

  AST_FWD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rev_i |=> par_o == {$past(par_o[W-LANES-1:0]), $past(a_i)}); // R2

  AST_REV_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_i |=> par_o == {$past(b_i), $past(par_o[W-1:LANES])}); // R3

  AST_B_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rev_i |-> b_o == par_o[W-1 -: LANES] && a_o == '0); // R5

  AST_A_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_i |-> a_o == par_o[LANES-1:0] && b_o == '0); // R6

  AST_OE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({a_oe_o, b_oe_o}) && (a_oe_o == rev_i)); // R7
endmodule

bind col_shift_reg col_shift_reg_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rev_i  (rev_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .a_o    (a_o),
  .a_oe_o (a_oe_o),
  .b_o    (b_o),
  .b_oe_o (b_oe_o),
  .par_o  (par_o)
);

// File: tb/col_shift_reg_tb_top.sv
module col_shift_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rev_i = 1'b0;
  logic [3:0]  a_i = '0;
  logic [3:0]  b_i = '0;
  logic [3:0]  a_o, b_o;
  logic        a_oe_o, b_oe_o;
  logic [63:0] par_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [3:0] mdl [16];

  always #5 clk = ~clk;

  col_shift_reg dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .rev_i  (rev_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .a_o    (a_o),
    .a_oe_o (a_oe_o),
    .b_o    (b_o),
    .b_oe_o (b_oe_o),
    .par_o  (par_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mdl_par();
    logic [63:0] r;
    for (int j = 0; j < 16; j++) r[j*4 +: 4] = mdl[j];
    return r;
  endfunction

  task automatic chk_all(input string tag);
    chk({tag, " par"}, par_o, mdl_par());
    if (rev_i) begin
      chk({tag, " R6 a_o"}, 64'(a_o), 64'(mdl[0]));
      chk({tag, " R7 b_o idle"}, 64'(b_o), 64'h0);
      chk({tag, " R7 oe"}, 64'({a_oe_o, b_oe_o}), 64'b10);
    end else begin
      chk({tag, " R5 b_o"}, 64'(b_o), 64'(mdl[15]));
      chk({tag, " R7 a_o idle"}, 64'(a_o), 64'h0);
      chk({tag, " R7 oe"}, 64'({a_oe_o, b_oe_o}), 64'b01);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic rv, input logic [3:0] a, input logic [3:0] b);
    rev_i = rv; a_i = a; b_i = b;
    if (!rv) begin
      for (int j = 15; j > 0; j--) mdl[j] = mdl[j-1];
      mdl[0] = a;
    end else begin
      for (int j = 0; j < 15; j++) mdl[j] = mdl[j+1];
      mdl[15] = b;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    for (int j = 0; j < 16; j++) mdl[j] = '0;
    chk("R1 par after reset", par_o, 64'h0);
    chk("R1 outputs after reset", 64'({a_o, b_o}), 64'h0);
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_map();
    do_reset();
    step(1'b0, 4'b0100, 4'hF);
    chk("R4 lane2 stage0 -> bit2", par_o, 64'h4);
    for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 4'hF);
    chk("R4 lane2 stage4 -> bit18", par_o, 64'h4_0000);
    step(1'b0, 4'b0001, 4'h0);
    chk("R4 lane0 stage0 -> bit0", par_o, 64'h4_0000_0 | 64'h1);
  endtask

  task automatic t_forward();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      logic [3:0] pat;
      pat = (i == 0) ? 4'h9 : 4'((i * 7 + 3) & 15);
      step(1'b0, pat, ~pat);
      chk_all("R2 R8 forward fill");
      if (i == 14) chk("R5 not yet at edge 15", 64'(b_o), 64'h0);
    end
    chk("R5 first nibble at edge 16", 64'(b_o), 64'h9);
  endtask

  task automatic t_reverse();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      logic [3:0] pat;
      pat = (i == 0) ? 4'h8 : 4'((i * 5 + 1) & 15);
      step(1'b1, ~pat, pat);
      if (i == 0) chk("R3 R4 lane3 enters at bit63", par_o, 64'h8000_0000_0000_0000);
      chk_all("R3 R8 reverse fill");
      if (i == 14) chk("R6 not yet at edge 15", 64'(a_o), 64'h0);
    end
    chk("R6 first nibble at edge 16", 64'(a_o), 64'h8);
  endtask

  task automatic t_turn();
    do_reset();
    step(1'b0, 4'h1, 4'hE);
    step(1'b0, 4'h2, 4'hD);
    step(1'b0, 4'h3, 4'hC);
    chk_all("R9 before turn");
    rev_i = 1'b1;
    b_i = 4'h0;
    #1;
    chk("R9 R7 enables follow rev_i at once", 64'({a_oe_o, b_oe_o}), 64'b10);
    chk("R9 newest nibble on a_o", 64'(a_o), 64'h3);
    step(1'b1, 4'hF, 4'h0);
    chk("R9 second nibble on a_o", 64'(a_o), 64'h2);
    step(1'b1, 4'hF, 4'h0);
    chk("R9 oldest nibble on a_o", 64'(a_o), 64'h1);
    chk_all("R9 after turn");
    rev_i = 1'b0;
    #1;
    chk("R7 enables back to forward", 64'({a_oe_o, b_oe_o}), 64'b01);
  endtask

  task automatic t_ignore();
    do_reset();
    step(1'b0, 4'hA, 4'h0);
    step(1'b0, 4'h5, 4'hF);
    chk("R8 b_i ignored forward", par_o, 64'hA5);
    step(1'b1, 4'hF, 4'h0);
    chk("R8 a_i ignored reverse", par_o, 64'hA);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 8; i++) step(1'b0, 4'hF, 4'h0);
    chk_all("R1 prefill");
    do_reset();
    chk("R1 reset clears filled register", par_o, 64'h0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_map();
    t_forward();
    t_reverse();
    t_turn();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all R act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule